// File: doc/BRIEF.md
# Framebuffer dirty-span scanner

This block keeps track of which parts of a framebuffer have been written since the last screen refresh. It then reports those parts as rectangles that span the full screen width. The screen is split into bands of four display lines. Three storage planes can mark a band:

- an indexed plane, with 4 KB of memory per band;
- a direct-color plane, with 16 KB per band;
- a control plane, with 16 KB per band.

Bus writes are snooped through a plane selector and a byte offset within that plane. Each write sets the dirty bit of the band it falls in.

On a refresh request the block walks the bands from top to bottom, one band per clock. It joins each run of adjacent dirty bands into one rectangle, given as a first line and a line count. Rectangles leave through a valid/ready handshake. Once the walk is done, the block clears the dirty bits of every plane between the lowest and the highest band it found dirty.

The direct-color and control planes count as dirty only in deep-color mode. An invalidate pulse forces a full redraw.

Top module: `fb_dirty_scan`

## Requirements
- R1: After reset no band of any plane is dirty, `rect_valid_o` is 0 and `scan_busy_o` is 0.
- R2: A snoop with plane code 0 (indexed) at byte offset A marks band A/4096 (A shifted right by 12).
- R3: A snoop with plane code 1 (direct color) or 2 (control) at byte offset A marks band A/16384 (A shifted right by 14). Such marks make a band dirty only while `deep_mode_i` is 1 at scan time.
- R4: A snoop whose band index is NUM_BANDS or more, or whose plane code is 3, marks nothing.
- R5: A refresh seen while idle raises `scan_busy_o` on the next cycle. With the output never stalled, busy stays high for NUM_BANDS+2 cycles. A refresh seen while busy is ignored.
- R6: The bands are visited from top to bottom. Each maximal run of adjacent dirty bands, starting at band S and lasting N bands, yields exactly one rectangle with line 4*S and count 4*N. A run that reaches the last band is reported at the end of the scan.
- R7: While `rect_valid_o` is 1 and `rect_ready_i` is 0, the output holds valid, line and count. The scan waits and does not drop or reorder a rectangle.
- R8: After the scan, every plane's bits from the lowest to the highest dirty band are cleared, including clean bands between them. Bits outside that range are kept. Nothing is cleared when no band was dirty.
- R9: A snoop during a scan leaves its band dirty for the next refresh, even inside the cleared range.
- R10: An invalidate pulse marks every band dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deep_mode_i | input | 1 | Direct-color and control marks count when 1 |
| snoop_valid_i | input | 1 | A write is observed this cycle |
| snoop_plane_i | input | 2 | Plane code: 0 indexed, 1 direct color, 2 control |
| snoop_addr_i | input | ADDR_W | Byte offset of the write within its plane |
| invalidate_i | input | 1 | Mark all bands dirty |
| refresh_i | input | 1 | Start a scan when idle |
| scan_busy_o | output | 1 | Scan in progress |
| rect_valid_o | output | 1 | Rectangle available |
| rect_ready_i | input | 1 | Consumer takes the rectangle |
| rect_line_o | output | LINE_W | First line of the rectangle |
| rect_count_o | output | LINE_W | Number of lines in the rectangle |

## Verification
Timing after each stimulus:
- A snoop or invalidate sets its dirty bit at the next edge. The bench therefore finishes every write one full cycle before it raises refresh.
- Busy is due one cycle after refresh is sampled, and with no stalls it lasts exactly NUM_BANDS+2 cycles. One directed test counts those cycles.
- A rectangle appears one edge after the scan visits the clean band that ends its run, or one edge after the final band. The bench does not predict that cycle. It samples valid and ready at the falling edge before the transferring edge, and it compares rectangles in order against a list computed from its own dirty model.
- Cleared bits are observed only through the next refresh, which the bench starts after busy and valid have both dropped.

// File: rtl/fbds_pkg.sv
package fbds_pkg;
  localparam int unsigned PLANES = 3;

  typedef enum logic [1:0] {
    PL_INDEX  = 2'd0,
    PL_DIRECT = 2'd1,
    PL_CTRL   = 2'd2
  } plane_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FLUSH,
    ST_CLEAR
  } scan_st_e;
endpackage

// File: rtl/fbds_band_decode.sv
module fbds_band_decode
  import fbds_pkg::*;
#(
  parameter int unsigned NUM_BANDS  = 48,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned WIDE_SHIFT = PAGE_SHIFT + 2
) (
  input  logic                              valid_i,
  input  logic [1:0]                        plane_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic [PLANES-1:0][NUM_BANDS-1:0]  set_o
);
  logic [ADDR_W-1:0] band_idx;

  // direct and control planes hold four bytes per indexed byte
  assign band_idx = (plane_i == PL_INDEX) ? (addr_i >> PAGE_SHIFT)
                                          : (addr_i >> WIDE_SHIFT);

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      assign set_o[p][b] = valid_i && (plane_i == 2'(p)) && (band_idx == ADDR_W'(b));
    end
  end
endmodule

// File: rtl/fbds_dirty_plane.sv
module fbds_dirty_plane #(
  parameter int unsigned NUM_BANDS = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANDS-1:0] set_i,
  input  logic [NUM_BANDS-1:0] clr_i,
  output logic [NUM_BANDS-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= (bits_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/fbds_span_scan.sv
module fbds_span_scan
  import fbds_pkg::*;
#(
  parameter int unsigned NUM_BANDS      = 48,
  parameter int unsigned LINES_PER_BAND = 4,
  localparam int unsigned BAND_W = $clog2(NUM_BANDS),
  localparam int unsigned LEN_W  = BAND_W + 1,
  localparam int unsigned LINE_W = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 refresh_i,
  input  logic [NUM_BANDS-1:0] dirty_i,
  input  logic [NUM_BANDS-1:0] touched_i,
  output logic                 busy_o,
  output logic [NUM_BANDS-1:0] clr_o,
  output logic                 rect_valid_o,
  input  logic                 rect_ready_i,
  output logic [LINE_W-1:0]    rect_line_o,
  output logic [LINE_W-1:0]    rect_count_o
);
  scan_st_e             st_q;
  logic [BAND_W-1:0]    idx_q, run_start_q, min_q, max_q, rect_start_q;
  logic [LEN_W-1:0]     run_len_q, rect_len_q;
  logic                 run_open_q, any_q, rect_valid_q;
  logic [NUM_BANDS-1:0] late_q, span;
  logic                 cur, slot_free, last_band, advance;

  assign cur       = dirty_i[idx_q];
  assign slot_free = !rect_valid_q || rect_ready_i;
  assign last_band = (idx_q == BAND_W'(NUM_BANDS - 1));
  assign advance   = cur || !run_open_q || slot_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      run_start_q  <= '0;
      run_len_q    <= '0;
      run_open_q   <= 1'b0;
      min_q        <= '0;
      max_q        <= '0;
      any_q        <= 1'b0;
      late_q       <= '0;
      rect_valid_q <= 1'b0;
      rect_start_q <= '0;
      rect_len_q   <= '0;
    end else begin
      if (rect_valid_q && rect_ready_i) rect_valid_q <= 1'b0;
      // writes seen during a scan must survive the clear
      if (st_q != ST_IDLE) late_q <= late_q | touched_i;
      unique case (st_q)
        ST_IDLE: begin
          if (refresh_i) begin
            st_q       <= ST_SCAN;
            idx_q      <= '0;
            any_q      <= 1'b0;
            run_open_q <= 1'b0;
            late_q     <= '0;
          end
        end
        ST_SCAN: begin
          if (cur) begin
            if (run_open_q) run_len_q <= run_len_q + 1'b1;
            else begin
              run_open_q  <= 1'b1;
              run_start_q <= idx_q;
              run_len_q   <= LEN_W'(1);
            end
            if (!any_q) min_q <= idx_q;
            any_q <= 1'b1;
            max_q <= idx_q;
          end else if (run_open_q && slot_free) begin
            rect_valid_q <= 1'b1;
            rect_start_q <= run_start_q;
            rect_len_q   <= run_len_q;
            run_open_q   <= 1'b0;
          end
          if (advance) begin
            if (last_band) st_q <= ST_FLUSH;
            else           idx_q <= idx_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (!run_open_q) st_q <= ST_CLEAR;
          else if (slot_free) begin
            rect_valid_q <= 1'b1;
            rect_start_q <= run_start_q;
            rect_len_q   <= run_len_q;
            run_open_q   <= 1'b0;
            st_q         <= ST_CLEAR;
          end
        end
        ST_CLEAR: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_span
    assign span[b] = any_q && (BAND_W'(b) >= min_q) && (BAND_W'(b) <= max_q);
  end

  assign clr_o        = (st_q == ST_CLEAR) ? (span & ~late_q) : '0;
  assign busy_o       = (st_q != ST_IDLE);
  assign rect_valid_o = rect_valid_q;
  assign rect_line_o  = LINE_W'(rect_start_q) * LINE_W'(LINES_PER_BAND);
  assign rect_count_o = LINE_W'(rect_len_q) * LINE_W'(LINES_PER_BAND);
endmodule

// File: rtl/fb_dirty_scan.sv
module fb_dirty_scan
  import fbds_pkg::*;
#(
  parameter int unsigned NUM_BANDS      = 48,
  parameter int unsigned LINES_PER_BAND = 4,
  parameter int unsigned ADDR_W         = 20,
  parameter int unsigned PAGE_SHIFT     = 12,
  localparam int unsigned LINE_W = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deep_mode_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_plane_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              invalidate_i,
  input  logic              refresh_i,
  output logic              scan_busy_o,
  output logic              rect_valid_o,
  input  logic              rect_ready_i,
  output logic [LINE_W-1:0] rect_line_o,
  output logic [LINE_W-1:0] rect_count_o
);
  logic [PLANES-1:0][NUM_BANDS-1:0] set_raw, set_pl, bits_pl;
  logic [NUM_BANDS-1:0] clr, dirty, touched;

  fbds_band_decode #(
    .NUM_BANDS (NUM_BANDS),
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_decode (
    .valid_i(snoop_valid_i),
    .plane_i(snoop_plane_i),
    .addr_i (snoop_addr_i),
    .set_o  (set_raw)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_pl
    if (p == 0) begin : g_inv
      assign set_pl[p] = set_raw[p] | {NUM_BANDS{invalidate_i}};
    end else begin : g_plain
      assign set_pl[p] = set_raw[p];
    end
    fbds_dirty_plane #(.NUM_BANDS(NUM_BANDS)) u_plane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_pl[p]),
      .clr_i (clr),
      .bits_o(bits_pl[p])
    );
  end

  assign touched = set_pl[0] | set_pl[1] | set_pl[2];
  assign dirty   = bits_pl[0] | (deep_mode_i ? (bits_pl[1] | bits_pl[2]) : '0);

  fbds_span_scan #(
    .NUM_BANDS     (NUM_BANDS),
    .LINES_PER_BAND(LINES_PER_BAND)
  ) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .refresh_i   (refresh_i),
    .dirty_i     (dirty),
    .touched_i   (touched),
    .busy_o      (scan_busy_o),
    .clr_o       (clr),
    .rect_valid_o(rect_valid_o),
    .rect_ready_i(rect_ready_i),
    .rect_line_o (rect_line_o),
    .rect_count_o(rect_count_o)
  );
endmodule

// File: rtl/fb_dirty_scan_chk.sv
module fb_dirty_scan_chk #(
  parameter int unsigned NUM_BANDS      = 48,
  parameter int unsigned LINES_PER_BAND = 4,
  localparam int unsigned LINE_W = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              refresh_i,
  input logic              scan_busy_o,
  input logic              rect_valid_o,
  input logic              rect_ready_i,
  input logic [LINE_W-1:0] rect_line_o,
  input logic [LINE_W-1:0] rect_count_o
);
  localparam int unsigned TOTAL = NUM_BANDS * LINES_PER_BAND;

  p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && !scan_busy_o |=> scan_busy_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_valid_o && !rect_ready_i |=>
      rect_valid_o && $stable(rect_line_o) && $stable(rect_count_o));

  p_bounds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_valid_o |-> (rect_count_o != '0) &&
      ((int'(rect_line_o) + int'(rect_count_o)) <= int'(TOTAL)) &&
      ((int'(rect_line_o) % int'(LINES_PER_BAND)) == 0));

  p_emit_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rect_valid_o) |-> scan_busy_o);
endmodule

bind fb_dirty_scan fb_dirty_scan_chk #(
  .NUM_BANDS     (NUM_BANDS),
  .LINES_PER_BAND(LINES_PER_BAND)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .refresh_i   (refresh_i),
  .scan_busy_o (scan_busy_o),
  .rect_valid_o(rect_valid_o),
  .rect_ready_i(rect_ready_i),
  .rect_line_o (rect_line_o),
  .rect_count_o(rect_count_o)
);

// File: tb/fb_dirty_scan_tb_top.sv
module fb_dirty_scan_tb_top;
  localparam int NB  = 48;
  localparam int LPB = 4;
  localparam int AW  = 20;
  localparam int LW  = $clog2(NB * LPB + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          deep = 1'b0, sv = 1'b0, inv = 1'b0, refresh = 1'b0, ready = 1'b1;
  logic [1:0]    splane = '0;
  logic [AW-1:0] saddr = '0;
  logic          busy, rvalid;
  logic [LW-1:0] rline, rcount;

  fb_dirty_scan #(.NUM_BANDS(NB), .LINES_PER_BAND(LPB), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .deep_mode_i(deep),
    .snoop_valid_i(sv), .snoop_plane_i(splane), .snoop_addr_i(saddr),
    .invalidate_i(inv), .refresh_i(refresh), .scan_busy_o(busy),
    .rect_valid_o(rvalid), .rect_ready_i(ready),
    .rect_line_o(rline), .rect_count_o(rcount)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [NB-1:0] m_pl [3];
  int exp_line [64];
  int exp_cnt  [64];
  int n_exp, lo, hi;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snoop(input int plane, input int addr);
    int band;
    @(negedge clk);
    sv = 1'b1; splane = 2'(plane); saddr = AW'(addr);
    @(negedge clk);
    sv = 1'b0;
    band = (plane == 0) ? (addr >> 12) : (addr >> 14);
    if (plane < 3 && band < NB) m_pl[plane][band] = 1'b1;
  endtask

  task automatic invalidate();
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    m_pl[0] = '1;
  endtask

  task automatic build_expected();
    logic [NB-1:0] comb;
    int start;
    comb = m_pl[0] | (deep ? (m_pl[1] | m_pl[2]) : '0);
    n_exp = 0; lo = -1; hi = -1; start = -1;
    for (int b = 0; b <= NB; b++) begin
      if (b < NB && comb[b]) begin
        if (lo < 0) lo = b;
        hi = b;
        if (start < 0) start = b;
      end else if (start >= 0) begin
        exp_line[n_exp] = start * LPB;
        exp_cnt[n_exp]  = (b - start) * LPB;
        n_exp++;
        start = -1;
      end
    end
  endtask

  // hold: cycles refresh stays high; late_band: indexed band written mid-scan
  task automatic do_refresh(input int hold, input int late_band, input bit bp, input string req);
    int k, n;
    bit stall;
    int sl, sc;
    build_expected();
    k = 0; n = 0; stall = 0; sl = 0; sc = 0;
    @(negedge clk); refresh = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R5 busy after refresh", int'(busy), 1);
    for (int g = 0; g < 5000; g++) begin
      bit r;
      refresh = (n < hold - 1);
      r = bp ? (($urandom % 3) != 0) : 1'b1;
      ready = r;
      if (stall) begin
        chk(rvalid && int'(rline) == sl && int'(rcount) == sc, "R7 held rectangle",
            int'(rline), sl);
      end
      if (!busy && !rvalid && !refresh) break;
      if (rvalid && r) begin
        if (k < n_exp) begin
          chk(int'(rline) == exp_line[k], {req, " line"}, int'(rline), exp_line[k]);
          chk(int'(rcount) == exp_cnt[k], {req, " count"}, int'(rcount), exp_cnt[k]);
        end else chk(1'b0, {req, " extra rectangle"}, k + 1, n_exp);
        k++;
      end
      stall = rvalid && !r;
      sl = int'(rline); sc = int'(rcount);
      if (late_band >= 0 && n == 10) begin
        sv = 1'b1; splane = 2'd0; saddr = AW'(late_band << 12);
      end else sv = 1'b0;
      n++;
      @(negedge clk);
    end
    sv = 1'b0; ready = 1'b1; refresh = 1'b0;
    chk(k == n_exp, {req, " rectangle count"}, k, n_exp);
    // R8 model: clear all planes over the dirty span
    if (lo >= 0)
      for (int b = lo; b <= hi; b++)
        for (int p = 0; p < 3; p++) m_pl[p][b] = 1'b0;
    if (late_band >= 0) m_pl[0][late_band] = 1'b1;  // R9
  endtask

  initial begin
    int nbusy;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 3; p++) m_pl[p] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && rvalid === 1'b0, "R1 reset outputs", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R5: a clean scan yields nothing and lasts NB+2 cycles
    refresh = 1'b1;
    @(negedge clk); refresh = 1'b0;
    nbusy = 0;
    for (int g = 0; g < 200 && busy; g++) begin
      if (rvalid) chk(1'b0, "R1 rectangle after reset", 1, 0);
      nbusy++;
      @(negedge clk);
    end
    chk(nbusy == NB + 2, "R5 busy length", nbusy, NB + 2);

    // R2: indexed offsets, run that needs merging
    snoop(0, 3 * 4096 + 17);
    snoop(0, 4 * 4096);
    snoop(0, 10 * 4096 + 4095);
    do_refresh(1, -1, 0, "R2 indexed bands");

    // R6: run ending at the last band plus the first band
    snoop(0, 0);
    snoop(0, (NB - 2) * 4096);
    snoop(0, (NB - 1) * 4096);
    do_refresh(1, -1, 1, "R6 edge runs");

    // R3: wide planes ignored without deep mode, counted with it
    deep = 1'b0;
    snoop(1, 5 * 16384 + 100);
    snoop(2, 6 * 16384);
    do_refresh(1, -1, 0, "R3 deep off");
    deep = 1'b1;
    do_refresh(1, -1, 0, "R3 deep on");
    deep = 1'b0;

    // R4: out-of-range band and plane code 3
    snoop(0, NB * 4096);
    snoop(3, 2 * 4096);
    deep = 1'b1;
    snoop(1, NB * 16384);
    do_refresh(1, -1, 0, "R4 ignored writes");
    deep = 1'b0;

    // R8: clean gap inside span is cleared, bands outside span kept
    snoop(0, 2 * 4096);
    snoop(0, 6 * 4096);
    snoop(1, 20 * 16384);
    do_refresh(1, -1, 0, "R8 first pass");
    deep = 1'b1;
    do_refresh(1, -1, 0, "R8 second pass");
    deep = 1'b0;

    // R9: rewrite of an already scanned band during the scan
    snoop(0, 2 * 4096);
    snoop(0, 3 * 4096);
    do_refresh(1, 2, 0, "R9 scan with late write");
    do_refresh(1, -1, 0, "R9 late band kept");

    // R10 with R5: refresh held high while busy starts one scan only
    invalidate();
    do_refresh(4, -1, 1, "R10 invalidate");
    do_refresh(1, -1, 0, "R10 after clear");

    // random mix
    for (int it = 0; it < 25; it++) begin
      int nw;
      deep = 1'($urandom % 2);
      nw = $urandom % 7;
      for (int w = 0; w < nw; w++) begin
        int pl, band, addr;
        pl = $urandom % 3;
        band = $urandom % (NB + 4);
        addr = (pl == 0) ? ((band << 12) | ($urandom % 4096))
                         : ((band << 14) | ($urandom % 16384));
        snoop(pl, addr);
      end
      if (($urandom % 8) == 0) invalidate();
      do_refresh(1, -1, 1, "R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule